// File: doc/BRIEF.md
# Bit-Field Extract Unit

This execution slice takes a source word and a control word that carries both a start position and a length. It copies the selected run of bits down to bit 0 of the result, with every bit above the run set to zero. The operation runs at 64 bits only when the caller requests the wide size and long mode is active. In every other case it runs at 32 bits. The control word comes either from a register-sized operand or from a 32-bit immediate, which is zero-extended before use. Alongside the result the unit produces arithmetic flags: carry and overflow always clear, zero set for an all-zero result, and the undefined flags driven to zero.

Operands enter through a valid/ready handshake. One register stage holds the result and flags. A transfer happens on a rising clock edge when `in_valid` and `in_ready` are both high. `out_valid` rises on the edge after the transfer. While `out_valid` is high and `out_ready` is low, the output stage keeps its contents and `in_ready` is held low. A new operand can enter in the same cycle that the previous result leaves, so the unit can accept one operation per clock.

Top module: `bfx_unit`

## Requirements
- R1: The start index is control bits [7:0], with 0 naming the least significant source bit. Result bit k holds source bit start+k, so the extracted run is right-justified.
- R2: The length is control bits [15:8]. Control bits from 16 upward have no effect on the result.
- R3: The effective width is 64 only when `in_wide_req` and `in_long_mode` are both 1, and 32 otherwise. At 32 bits, source bits [63:32] are ignored and result bits [63:32] are 0.
- R4: Source positions at or beyond the effective width read as zero. A start index at or past the width therefore yields a zero result.
- R5: A length of 0 yields zero. A length above the effective width saturates to it. Result bits at and above the length are 0.
- R6: When `in_imm_form` is 1, the control word is `in_ctrl_imm` zero-extended and `in_ctrl_reg` is ignored. When it is 0, `in_ctrl_reg` is used.
- R7: `out_cf` and `out_of` are 0 and `out_zf` is 1 exactly when `out_result` is zero. `out_pf`, `out_af` and `out_sf` are driven 0 and carry no defined meaning.
- R8: A transferred operation appears on the outputs with `out_valid` one clock later. While `out_valid`=1 and `out_ready`=0, the outputs hold unchanged.
- R9: `in_ready` is 0 exactly when `out_valid`=1 and `out_ready`=0.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| in_src | input | 64 | Source word |
| in_ctrl_reg | input | 64 | Register-form control word |
| in_ctrl_imm | input | 32 | Immediate-form control word |
| in_imm_form | input | 1 | 1 selects the immediate control |
| in_wide_req | input | 1 | Request for 64-bit operation |
| in_long_mode | input | 1 | Long mode active; enables the 64-bit size |
| out_valid | output | 1 | Result and flags valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Extracted field, right-justified |
| out_cf | output | 1 | Carry flag (always 0) |
| out_of | output | 1 | Overflow flag (always 0) |
| out_zf | output | 1 | Zero flag |
| out_sf | output | 1 | Sign flag, undefined, driven 0 |
| out_pf | output | 1 | Parity flag, undefined, driven 0 |
| out_af | output | 1 | Auxiliary-carry flag, undefined, driven 0 |

## Verification
The assertions assume that every operand and mode input holds a known value at each rising edge once reset is released, because they sample the combinational extract path directly. They also assume that the consumer may stall for any number of cycles. The stimulus therefore drives all inputs to defined values from time zero and changes them only on falling edges. It toggles `out_ready` at random in the stall phase, so the hold and back-pressure properties see long and short stalls.

// File: rtl/bfx_pkg.sv
`timescale 1ns/1ps
package bfx_pkg;
  // Widths shared by the unit and its parts
  parameter int unsigned DATA_W   = 64;
  parameter int unsigned NARROW_W = 32;
  parameter int unsigned IMM_W    = 32;
  parameter int unsigned FIELD_W  = 8;

  typedef enum logic {
    SIZE_NARROW = 1'b0,
    SIZE_WIDE   = 1'b1
  } bfx_size_e;
endpackage

// File: rtl/bfx_ctrl_decode.sv
`timescale 1ns/1ps
module bfx_ctrl_decode
  import bfx_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IMM_W,
  parameter int unsigned FW = FIELD_W
) (
  input  logic [DW-1:0] ctrl_reg,
  input  logic [IW-1:0] ctrl_imm,
  input  logic          imm_form,
  input  logic          wide_req,
  input  logic          long_mode,
  output logic [FW-1:0] start,
  output logic [FW-1:0] len,
  output bfx_size_e     size
);
  localparam int unsigned USED_W = 2 * FW;

  logic [DW-1:0] ctrl;
  logic          unused_ctrl_hi;

  // Immediate control is zero-extended to the operand width
  always_comb begin
    if (imm_form) ctrl = DW'(ctrl_imm);
    else          ctrl = ctrl_reg;
  end

  assign start = ctrl[FW-1:0];
  assign len   = ctrl[USED_W-1:FW];
  assign unused_ctrl_hi = ^ctrl[DW-1:USED_W];

  // Wide only when both the request and long mode are present
  assign size = (wide_req && long_mode) ? SIZE_WIDE : SIZE_NARROW;
endmodule

// File: rtl/bfx_extract.sv
`timescale 1ns/1ps
module bfx_extract
  import bfx_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NARROW_W,
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src,
  input  logic [FW-1:0] start,
  input  logic [FW-1:0] len,
  input  bfx_size_e     size,
  output logic [DW-1:0] result
);
  localparam int unsigned IDX_W = $clog2(DW);
  localparam logic [FW-1:0] DW_LIM = FW'(DW);
  localparam logic [FW-1:0] NW_LIM = FW'(NW);

  logic [DW-1:0] src_m;
  logic [DW-1:0] shifted;
  logic [DW-1:0] keep;

  // Clear positions beyond the effective width
  always_comb begin
    src_m = src;
    if (size == SIZE_NARROW) src_m[DW-1:NW] = '0;
  end

  // Right-justify from the start index; far starts give zero
  always_comb begin
    if (start >= DW_LIM) shifted = '0;
    else                 shifted = src_m >> start[IDX_W-1:0];
  end

  // Thermometer mask: a length past the width saturates on its own
  for (genvar i = 0; i < DW; i++) begin : g_keep
    localparam logic [FW-1:0] POS = FW'(i);
    assign keep[i] = (len > POS);
  end

  assign result = shifted & keep;

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len == '0) |-> (result == '0));

  // R3
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SIZE_NARROW) |-> (result[DW-1:NW] == '0));

  // R4
  far_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((size == SIZE_NARROW) && (start >= NW_LIM)) |-> (result == '0));
endmodule

// File: rtl/bfx_out_stage.sv
`timescale 1ns/1ps
module bfx_out_stage
  import bfx_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_result,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_result,
  output logic          dn_zf
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_result <= '0;
      dn_zf     <= 1'b1;
    end else if (take) begin
      dn_result <= up_result;
      dn_zf     <= (up_result == '0);
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_result) && $stable(dn_zf)));

  // R8
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_valid) |-> $past(up_valid));

  // R9
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !up_valid) |=> !dn_valid);

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_zf == (dn_result == '0)));
endmodule

// File: rtl/bfx_unit.sv
`timescale 1ns/1ps
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NARROW_W,
  parameter int unsigned IW = IMM_W,
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_src,
  input  logic [DW-1:0] in_ctrl_reg,
  input  logic [IW-1:0] in_ctrl_imm,
  input  logic          in_imm_form,
  input  logic          in_wide_req,
  input  logic          in_long_mode,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_cf,
  output logic          out_of,
  output logic          out_zf,
  output logic          out_sf,
  output logic          out_pf,
  output logic          out_af
);
  logic [FW-1:0] start;
  logic [FW-1:0] len;
  bfx_size_e     size;
  logic [DW-1:0] ext_result;

  bfx_ctrl_decode #(.DW(DW), .IW(IW), .FW(FW)) decode_i (
    .ctrl_reg  (in_ctrl_reg),
    .ctrl_imm  (in_ctrl_imm),
    .imm_form  (in_imm_form),
    .wide_req  (in_wide_req),
    .long_mode (in_long_mode),
    .start     (start),
    .len       (len),
    .size      (size)
  );

  bfx_extract #(.DW(DW), .NW(NW), .FW(FW)) extract_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (in_src),
    .start  (start),
    .len    (len),
    .size   (size),
    .result (ext_result)
  );

  bfx_out_stage #(.DW(DW)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_valid  (in_valid),
    .up_ready  (in_ready),
    .up_result (ext_result),
    .dn_valid  (out_valid),
    .dn_ready  (out_ready),
    .dn_result (out_result),
    .dn_zf     (out_zf)
  );

  // Fixed flags: cleared, or undefined and tied low
  assign out_cf = 1'b0;
  assign out_of = 1'b0;
  assign out_sf = 1'b0;
  assign out_pf = 1'b0;
  assign out_af = 1'b0;

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

// File: tb/bfx_unit_tb_top.sv
`timescale 1ns/1ps
module bfx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [63:0] in_ctrl_reg = '0;
  logic [31:0] in_ctrl_imm = '0;
  logic        in_imm_form = 1'b0;
  logic        in_wide_req = 1'b0;
  logic        in_long_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_cf, out_of, out_zf, out_sf, out_pf, out_af;

  int    n_total = 0;
  int    n_fail  = 0;
  string cur_req = "R10";
  bit    bp_en   = 1'b0;
  bit    done    = 1'b0;

  bit          mv = 1'b0;
  logic [63:0] md = '0;
  string       md_tag = "";

  always #10 clk = ~clk;

  bfx_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_ctrl_reg(in_ctrl_reg), .in_ctrl_imm(in_ctrl_imm),
    .in_imm_form(in_imm_form), .in_wide_req(in_wide_req), .in_long_mode(in_long_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_cf(out_cf), .out_of(out_of), .out_zf(out_zf),
    .out_sf(out_sf), .out_pf(out_pf), .out_af(out_af)
  );

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: bit-by-bit copy from the requirements
  function automatic logic [63:0] ref_fx(logic [63:0] src, logic [63:0] creg,
                                         logic [31:0] imm, bit immf, bit wide, bit lm);
    logic [63:0] c;
    logic [63:0] r;
    int s, l, w;
    c = immf ? {32'h0, imm} : creg;
    s = int'(c[7:0]);
    l = int'(c[15:8]);
    w = (wide && lm) ? 64 : 32;
    r = '0;
    for (int i = 0; i < 64; i++)
      if (i < l && (s + i) < w) r[i] = src[s + i];
    return r;
  endfunction

  // Cycle model, compared a quarter period after each falling edge
  always begin
    @(negedge clk);
    #5;
    if (!rst_n) begin
      mv = 1'b0;
    end else if (!done) begin
      chk(out_valid === mv, "R8", "out_valid", 64'(out_valid), 64'(mv));
      if (mv) begin
        chk(out_result === md, md_tag, "result", out_result, md);
        chk(out_zf === (md == 64'h0), "R7", "zf", 64'(out_zf), 64'(md == 64'h0));
        chk((out_cf === 1'b0) && (out_of === 1'b0), "R7", "cf/of",
            64'({out_cf, out_of}), 64'h0);
      end
      chk(in_ready === (!mv || out_ready), "R9", "in_ready",
          64'(in_ready), 64'(!mv || out_ready));
      if (!mv || out_ready) begin
        mv = in_valid;
        if (in_valid) begin
          md = ref_fx(in_src, in_ctrl_reg, in_ctrl_imm, in_imm_form,
                      in_wide_req, in_long_mode);
          md_tag = cur_req;
        end
      end
    end
  end

  always @(negedge clk) out_ready = bp_en ? 1'($urandom % 2) : 1'b1;

  // Called at a falling edge; returns at the falling edge after transfer
  task automatic send(logic [63:0] src, logic [63:0] creg, logic [31:0] imm,
                      bit immf, bit wide, bit lm);
    bit acc;
    in_valid = 1'b1; in_src = src; in_ctrl_reg = creg; in_ctrl_imm = imm;
    in_imm_form = immf; in_wide_req = wide; in_long_mode = lm;
    do begin
      #5 acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] cw(int start, int len, logic [47:0] junk);
    return {junk, 8'(len), 8'(start)};
  endfunction

  localparam logic [63:0] PAT = 64'hF0E1_D2C3_B4A5_9687;

  initial begin
    repeat (4) @(negedge clk);
    #5;
    chk(out_valid === 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'h0);
    chk(in_ready === 1'b1, "R10", "in_ready in reset", 64'(in_ready), 64'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    chk(out_valid === 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'h0);
    @(negedge clk);

    cur_req = "R1";
    for (int s = 0; s < 64; s += 7) send(PAT, cw(s, 12, 48'h0), 32'h0, 0, 1, 1);
    send(64'h1, cw(0, 1, 48'h0), 32'h0, 0, 1, 1);
    send(64'h8000_0000_0000_0000, cw(63, 1, 48'h0), 32'h0, 0, 1, 1);

    cur_req = "R2";
    send(PAT, cw(4, 20, 48'hFFFF_FFFF_FFFF), 32'h0, 0, 1, 1);
    send(PAT, cw(9, 33, 48'hA5A5_0000_5A5A), 32'h0, 0, 1, 1);

    cur_req = "R3";
    send(64'hFFFF_FFFF_0000_0000, cw(16, 40, 48'h0), 32'h0, 0, 1, 0);
    send(64'hFFFF_FFFF_FFFF_FFFF, cw(0, 64, 48'h0), 32'h0, 0, 1, 0);
    send(64'hFFFF_FFFF_FFFF_FFFF, cw(0, 64, 48'h0), 32'h0, 0, 0, 1);
    send(64'hFFFF_FFFF_FFFF_FFFF, cw(0, 64, 48'h0), 32'h0, 0, 1, 1);
    send(PAT, cw(28, 8, 48'h0), 32'h0, 0, 0, 0);

    cur_req = "R4";
    send(PAT, cw(32, 8, 48'h0), 32'h0, 0, 0, 0);
    send(PAT, cw(40, 8, 48'h0), 32'h0, 0, 1, 1);
    send(PAT, cw(63, 8, 48'h0), 32'h0, 0, 1, 1);
    send(PAT, cw(64, 8, 48'h0), 32'h0, 0, 1, 1);
    send(PAT, cw(200, 255, 48'h0), 32'h0, 0, 1, 1);

    cur_req = "R5";
    send(PAT, cw(3, 0, 48'h0), 32'h0, 0, 1, 1);
    send(PAT, cw(0, 64, 48'h0), 32'h0, 0, 1, 1);
    send(PAT, cw(5, 100, 48'h0), 32'h0, 0, 1, 1);
    send(PAT, cw(5, 255, 48'h0), 32'h0, 0, 0, 0);
    send(PAT, cw(31, 2, 48'h0), 32'h0, 0, 0, 0);

    cur_req = "R6";
    send(PAT, cw(0, 4, 48'h0), {16'hFFFF, 8'd16, 8'd8}, 1, 1, 1);
    send(PAT, 64'hFFFF_FFFF_FFFF_FFFF, {16'h0, 8'd32, 8'd32}, 1, 1, 1);
    send(PAT, cw(8, 16, 48'h0), 32'h0, 1, 1, 1);

    cur_req = "R7";
    send(64'h0, cw(0, 64, 48'h0), 32'h0, 0, 1, 1);
    send(64'h0000_0000_0000_0F00, cw(0, 8, 48'h0), 32'h0, 0, 1, 1);
    send(64'h0000_0000_0000_0F00, cw(8, 8, 48'h0), 32'h0, 0, 1, 1);

    cur_req = "R8";
    bp_en = 1'b1;
    for (int k = 0; k < 400; k++) begin
      logic [63:0] c;
      c = {$urandom, $urandom};
      c[7:0]  = 8'($urandom % 72);
      c[15:8] = 8'($urandom % 72);
      send({$urandom, $urandom}, c, 32'(c[15:0]) | ($urandom & 32'hFFFF_0000),
           1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 4 != 0));
      if ($urandom % 4 == 0) @(negedge clk);
    end
    cur_req = "R9";
    bp_en = 1'b0;
    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule